// File: doc/BRIEF.md
# Branch Target Buffer with Return Stack

This block predicts the next fetch address of an in-order pipeline. Each fetch address is searched in a small fully associative table. The table holds pairs of a control-transfer address and the target that transfer last went to. A hit steers the next fetch to the stored target. A miss lets fetch continue at the sequential address, four bytes on. For return instructions, a four-deep stack of return addresses overrides the table. The stack is filled when a call is fetched.

When a branch resolves later in the pipeline, the block is given the branch address, its real outcome, its target and the next address that fetch actually used. A taken transfer is installed in the table, or its stored target is refreshed. A not-taken branch that sits in the table is removed. Not-taken branches are never installed. If the real next address differs from the one fetch used, the block raises a one-cycle flush together with the corrected address. It then ignores resolve reports for the three slots being aborted.

A small state machine sequences the flush. It has four states. `ST_RUN` accepts resolve reports. `ST_KILL0` drives the flush pulse. `ST_KILL1` and `ST_KILL2` keep the window closed for the remaining aborted slots. The transitions are:
- `ST_RUN` goes to `ST_KILL0` on an accepted mispredict, and otherwise stays in `ST_RUN`.
- `ST_KILL0` goes to `ST_KILL1`.
- `ST_KILL1` goes to `ST_KILL2`.
- `ST_KILL2` goes back to `ST_RUN`.

Top module: `btb_predictor`

## Requirements
- R1: After reset every table entry is invalid, the return stack is empty and `flush_o` is low. Every fetch therefore misses, with `pred_hit_o`=0, `ras_used_o`=0 and `pred_pc_o` = `fetch_pc_i`+4.
- R2: An accepted resolve with `res_taken_i`=1 for an address not in the table allocates an entry. From the next cycle, a fetch of that address gives `pred_hit_o`=1 and `pred_pc_o` = the resolved target.
- R3: An accepted resolve with `res_taken_i`=0 for an address not in the table allocates nothing. A later fetch of that address still misses.
- R4: The table has 8 entries, filled and replaced in round-robin order. After 8 allocations, the next allocation replaces the entry allocated first, and the other seven stay.
- R5: An accepted resolve with `res_taken_i`=0 for an address present in the table invalidates that entry.
- R6: The real next address is `res_target_i` when taken, and `res_pc_i`+4 otherwise. When an accepted resolve's real next address differs from `res_pred_pc_i`, `flush_o`=1 in the cycle after the resolving clock edge, with `fix_pc_o` = the real next address. When the two match, no flush is raised.
- R7: `flush_o` is high for exactly one cycle per mispredict.
- R8: Resolve reports sampled at the three clock edges after an accepted mispredict are ignored. They cause no table change and no flush.
- R9: A fetch with `fetch_call_i`=1 pushes `fetch_pc_i`+4. A later fetch with `fetch_ret_i`=1 and a non-empty stack predicts the top of the stack, ahead of any table hit, with `ras_used_o`=1. It also pops the stack.
- R10: The stack holds 4 addresses. A fifth push overwrites the oldest one. Popping afterwards yields the 4 newest addresses, newest first, and then the stack is empty.
- R11: A return fetched with an empty stack falls back to the table hit, or to `fetch_pc_i`+4, with `ras_used_o`=0.
- R12: A taken resolve of an address already in the table rewrites its target in place. It does not advance the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | A fetch occurs this cycle |
| fetch_pc_i | input | 32 | Address being fetched |
| fetch_call_i | input | 1 | Fetched instruction is a call that links the return register |
| fetch_ret_i | input | 1 | Fetched instruction is a return through the return register |
| pred_pc_o | output | 32 | Predicted next fetch address |
| pred_hit_o | output | 1 | Table hit for the fetch address |
| ras_used_o | output | 1 | Prediction taken from the return stack |
| res_valid_i | input | 1 | A control transfer resolves this cycle |
| res_pc_i | input | 32 | Address of the resolving transfer |
| res_taken_i | input | 1 | The transfer was taken |
| res_target_i | input | 32 | Target of the transfer |
| res_pred_pc_i | input | 32 | Next address that fetch used after this transfer |
| flush_o | output | 1 | One-cycle flush of the younger slots |
| fix_pc_o | output | 32 | Corrected fetch address, valid with `flush_o` |

## Verification
The prediction outputs are combinational. They are checked one nanosecond after the fetch inputs change on the falling edge, and before the edge that updates the stack. Table and stack updates take effect at the next rising edge, so lookups that follow a resolve or a push are driven from the next falling edge onward. `flush_o` and `fix_pc_o` come from a register. They are sampled on the falling edge after the resolving rising edge, and again one cycle later to confirm the pulse has dropped. For the ignore window, resolve inputs are held across exactly the three following rising edges, and `flush_o` is checked low at each of them.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int unsigned INSN_BYTES = 4;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_KILL0 = 2'd1,
        ST_KILL1 = 2'd2,
        ST_KILL2 = 2'd3
    } flush_state_e;

endpackage

// File: rtl/btb_table.sv
module btb_table #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic [PC_W-1:0] look_pc_i,
    output logic            look_hit_o,
    output logic [PC_W-1:0] look_tgt_o,
    input  logic            upd_en_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i,
    input  logic [PC_W-1:0] upd_tgt_i
);

    logic [ENTRIES-1:0] valid_q;
    logic [PC_W-1:0]    tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;

    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] upd_match;
    logic [IDX_W-1:0]   look_idx;
    logic [IDX_W-1:0]   upd_idx;
    logic               upd_hit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
        assign look_match[g] = valid_q[g] && (tag_q[g] == look_pc_i);
        assign upd_match[g]  = valid_q[g] && (tag_q[g] == upd_pc_i);
    end

    always_comb begin
        look_idx = '0;
        upd_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (look_match[i]) look_idx = IDX_W'(i);
            if (upd_match[i])  upd_idx  = IDX_W'(i);
        end
    end

    assign look_hit_o = |look_match;
    assign upd_hit    = |upd_match;
    assign look_tgt_o = tgt_q[look_idx];

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (upd_en_i) begin
            if (upd_taken_i) begin
                if (upd_hit) begin
                    tgt_q[upd_idx] <= upd_tgt_i;
                end else begin
                    valid_q[rr_q] <= 1'b1;
                    tag_q[rr_q]   <= upd_pc_i;
                    tgt_q[rr_q]   <= upd_tgt_i;
                    rr_q          <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
                end
            end else if (upd_hit) begin
                valid_q[upd_idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/btb_ras.sv
module btb_ras #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] push_addr_i,
    output logic [PC_W-1:0] top_o,
    output logic            empty_o
);

    logic [PC_W-1:0]  slot_q [DEPTH];
    logic [PTR_W-1:0] top_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] up_ptr;
    logic [PTR_W-1:0] down_ptr;

    assign up_ptr   = (top_q == PTR_W'(DEPTH - 1)) ? '0 : top_q + 1'b1;
    assign down_ptr = (top_q == '0) ? PTR_W'(DEPTH - 1) : top_q - 1'b1;
    assign empty_o  = (cnt_q == '0);
    assign top_o    = slot_q[top_q];

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            top_q <= '0;
            cnt_q <= '0;
        end else if (push_i && pop_i && !empty_o) begin
            slot_q[top_q] <= push_addr_i;
        end else if (push_i) begin
            slot_q[up_ptr] <= push_addr_i;
            top_q          <= up_ptr;
            if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            top_q <= down_ptr;
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/btb_flush_ctl.sv
module btb_flush_ctl
    import btb_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            mispredict_i,
    input  logic [PC_W-1:0] real_pc_i,
    output logic            accept_o,
    output logic            flush_o,
    output logic [PC_W-1:0] fix_pc_o
);

    flush_state_e state_q;
    flush_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (mispredict_i) state_d = ST_KILL0;
            ST_KILL0: state_d = ST_KILL1;
            ST_KILL1: state_d = ST_KILL2;
            ST_KILL2: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q  <= ST_RUN;
            fix_pc_o <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && mispredict_i) fix_pc_o <= real_pc_i;
        end
    end

    always_comb begin
        accept_o = 1'b0;
        flush_o  = 1'b0;
        unique case (state_q)
            ST_RUN:   accept_o = 1'b1;
            ST_KILL0: flush_o  = 1'b1;
            ST_KILL1: ;
            ST_KILL2: ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ENTRIES   = 8,
    parameter int unsigned RAS_DEPTH = 4
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            fetch_valid_i,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            fetch_call_i,
    input  logic            fetch_ret_i,
    output logic [PC_W-1:0] pred_pc_o,
    output logic            pred_hit_o,
    output logic            ras_used_o,
    input  logic            res_valid_i,
    input  logic [PC_W-1:0] res_pc_i,
    input  logic            res_taken_i,
    input  logic [PC_W-1:0] res_target_i,
    input  logic [PC_W-1:0] res_pred_pc_i,
    output logic            flush_o,
    output logic [PC_W-1:0] fix_pc_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic            accept;
    logic            upd_en;
    logic [PC_W-1:0] real_next;
    logic            mispredict;
    logic            tbl_hit;
    logic [PC_W-1:0] tbl_tgt;
    logic [PC_W-1:0] ras_top;
    logic            ras_empty;
    logic [PC_W-1:0] seq_pc;

    assign seq_pc     = fetch_pc_i + STEP;
    assign real_next  = res_taken_i ? res_target_i : (res_pc_i + STEP);
    assign upd_en     = res_valid_i && accept;
    assign mispredict = res_valid_i && (real_next != res_pred_pc_i);

    btb_table #(
        .PC_W    (PC_W),
        .ENTRIES (ENTRIES)
    ) table_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .look_pc_i   (fetch_pc_i),
        .look_hit_o  (tbl_hit),
        .look_tgt_o  (tbl_tgt),
        .upd_en_i    (upd_en),
        .upd_pc_i    (res_pc_i),
        .upd_taken_i (res_taken_i),
        .upd_tgt_i   (res_target_i)
    );

    btb_ras #(
        .PC_W  (PC_W),
        .DEPTH (RAS_DEPTH)
    ) ras_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .push_i      (fetch_valid_i && fetch_call_i),
        .pop_i       (fetch_valid_i && fetch_ret_i),
        .push_addr_i (seq_pc),
        .top_o       (ras_top),
        .empty_o     (ras_empty)
    );

    btb_flush_ctl #(
        .PC_W (PC_W)
    ) flush_i (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .mispredict_i (mispredict),
        .real_pc_i    (real_next),
        .accept_o     (accept),
        .flush_o      (flush_o),
        .fix_pc_o     (fix_pc_o)
    );

    always_comb begin
        ras_used_o = fetch_valid_i && fetch_ret_i && !ras_empty;
        pred_hit_o = tbl_hit;
        if (ras_used_o)   pred_pc_o = ras_top;
        else if (tbl_hit) pred_pc_o = tbl_tgt;
        else              pred_pc_o = seq_pc;
    end

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk_i,
    input logic            rst_n_i,
    input logic            fetch_valid_i,
    input logic [PC_W-1:0] fetch_pc_i,
    input logic            fetch_call_i,
    input logic            fetch_ret_i,
    input logic [PC_W-1:0] pred_pc_o,
    input logic            pred_hit_o,
    input logic            ras_used_o,
    input logic            res_valid_i,
    input logic [PC_W-1:0] res_pc_i,
    input logic            res_taken_i,
    input logic [PC_W-1:0] res_target_i,
    input logic [PC_W-1:0] res_pred_pc_i,
    input logic            flush_o,
    input logic [PC_W-1:0] fix_pc_o
);

    localparam logic [PC_W-1:0] FOUR = PC_W'(4);

    p_fallthrough_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!pred_hit_o && !ras_used_o) |-> (pred_pc_o == fetch_pc_i + FOUR));

    p_flush_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        flush_o |-> ($past(res_valid_i) && fix_pc_o == ($past(res_taken_i) ?
            $past(res_target_i) : $past(res_pc_i) + FOUR)));

    p_no_flush_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (res_valid_i && res_pred_pc_i == (res_taken_i ? res_target_i : res_pc_i + FOUR))
        |=> !flush_o);

    p_one_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        flush_o |=> !flush_o);

    p_quiet_window_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        flush_o |=> (!flush_o ##1 !flush_o ##1 !flush_o));

    p_ras_only_ret_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ras_used_o |-> (fetch_valid_i && fetch_ret_i));

    p_call_then_ret_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (fetch_valid_i && fetch_ret_i && $past(fetch_valid_i && fetch_call_i && !fetch_ret_i))
        |-> (ras_used_o && pred_pc_o == $past(fetch_pc_i) + FOUR));

endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) chk_i (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_pc_i    (fetch_pc_i),
    .fetch_call_i  (fetch_call_i),
    .fetch_ret_i   (fetch_ret_i),
    .pred_pc_o     (pred_pc_o),
    .pred_hit_o    (pred_hit_o),
    .ras_used_o    (ras_used_o),
    .res_valid_i   (res_valid_i),
    .res_pc_i      (res_pc_i),
    .res_taken_i   (res_taken_i),
    .res_target_i  (res_target_i),
    .res_pred_pc_i (res_pred_pc_i),
    .flush_o       (flush_o),
    .fix_pc_o      (fix_pc_o)
);

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid, fetch_call, fetch_ret;
    logic [31:0] fetch_pc;
    logic [31:0] pred_pc;
    logic        pred_hit, ras_used;
    logic        res_valid, res_taken;
    logic [31:0] res_pc, res_target, res_pred_pc;
    logic        flush;
    logic [31:0] fix_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    btb_predictor dut_i (
        .clk_i(clk), .rst_n_i(rst_n),
        .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
        .fetch_call_i(fetch_call), .fetch_ret_i(fetch_ret),
        .pred_pc_o(pred_pc), .pred_hit_o(pred_hit), .ras_used_o(ras_used),
        .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
        .res_target_i(res_target), .res_pred_pc_i(res_pred_pc),
        .flush_o(flush), .fix_pc_o(fix_pc)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] a_pc(int i);
        return 32'h100 + 32'(i) * 32'h10;
    endfunction

    function automatic logic [31:0] a_tgt(int i);
        return 32'h800 + 32'(i) * 32'h40;
    endfunction

    // One fetch: drive at falling edge, check combinational prediction, hold for one rising edge.
    task automatic fetch_op(string req, logic [31:0] pc, logic call, logic ret,
                            logic [31:0] exp_pc, logic exp_hit, logic exp_ras);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_pc = pc; fetch_call = call; fetch_ret = ret;
        #1;
        check(req, pred_pc, exp_pc);
        check(req, {31'd0, pred_hit}, {31'd0, exp_hit});
        check(req, {31'd0, ras_used}, {31'd0, exp_ras});
        @(posedge clk); #1;
        fetch_valid = 1'b0; fetch_call = 1'b0; fetch_ret = 1'b0;
    endtask

    // One resolve: flush is due at the falling edge after the resolving rising edge.
    task automatic resolve(string req, logic [31:0] pc, logic tk, logic [31:0] tgt,
                           logic [31:0] used);
        logic [31:0] real_nx;
        logic        exp_fl;
        real_nx = tk ? tgt : pc + 32'd4;
        exp_fl  = (real_nx != used);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt; res_pred_pc = used;
        @(posedge clk); #1;
        res_valid = 1'b0;
        @(negedge clk);
        check(req, {31'd0, flush}, {31'd0, exp_fl});
        if (exp_fl) check(req, fix_pc, real_nx);
        @(negedge clk);
        check("R7", {31'd0, flush}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        fetch_valid = 1'b0; fetch_call = 1'b0; fetch_ret = 1'b0; fetch_pc = '0;
        res_valid = 1'b0; res_taken = 1'b0; res_pc = '0; res_target = '0; res_pred_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, sweep of fetch addresses
        check("R1", {31'd0, flush}, 32'd0);
        for (int i = 0; i < 64; i++) begin
            fetch_op("R1", 32'(i) * 32'd4, 1'b0, 1'b0, 32'(i) * 32'd4 + 32'd4, 1'b0, 1'b0);
        end

        // R2/R6: allocate 8 taken branches, each a mispredict against the sequential guess
        for (int i = 0; i < 8; i++) begin
            resolve("R6", a_pc(i), 1'b1, a_tgt(i), a_pc(i) + 32'd4);
        end
        for (int i = 0; i < 8; i++) begin
            fetch_op("R2", a_pc(i), 1'b0, 1'b0, a_tgt(i), 1'b1, 1'b0);
        end

        // R3: not-taken miss is not allocated and needs no flush
        resolve("R3", 32'h400, 1'b0, 32'hC00, 32'h404);
        fetch_op("R3", 32'h400, 1'b0, 1'b0, 32'h404, 1'b0, 1'b0);

        // R12: retarget entry 3 in place
        resolve("R12", a_pc(3), 1'b1, 32'h900, a_tgt(3));
        fetch_op("R12", a_pc(3), 1'b0, 1'b0, 32'h900, 1'b1, 1'b0);

        // R4: ninth allocation replaces entry 0 only
        resolve("R4", 32'h500, 1'b1, 32'hA00, 32'h504);
        fetch_op("R4", a_pc(0), 1'b0, 1'b0, a_pc(0) + 32'd4, 1'b0, 1'b0);
        for (int i = 1; i < 8; i++) begin
            fetch_op("R4", a_pc(i), 1'b0, 1'b0, (i == 3) ? 32'h900 : a_tgt(i), 1'b1, 1'b0);
        end
        fetch_op("R4", 32'h500, 1'b0, 1'b0, 32'hA00, 1'b1, 1'b0);

        // R5: predicted-taken branch goes not taken: invalidated, flush to fall-through
        resolve("R5", a_pc(1), 1'b0, a_tgt(1), a_tgt(1));
        fetch_op("R5", a_pc(1), 1'b0, 1'b0, a_pc(1) + 32'd4, 1'b0, 1'b0);

        // R6: correct prediction, no flush, entry kept
        resolve("R6", a_pc(2), 1'b1, a_tgt(2), a_tgt(2));
        fetch_op("R6", a_pc(2), 1'b0, 1'b0, a_tgt(2), 1'b1, 1'b0);

        // R8: resolve held across the three edges after a mispredict is ignored
        @(negedge clk);
        res_valid = 1'b1; res_pc = a_pc(4); res_taken = 1'b0;
        res_target = a_tgt(4); res_pred_pc = a_tgt(4);
        @(negedge clk);
        check("R6", {31'd0, flush}, 32'd1);
        check("R6", fix_pc, a_pc(4) + 32'd4);
        res_pc = 32'h600; res_taken = 1'b1; res_target = 32'hE00; res_pred_pc = 32'h604;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8", {31'd0, flush}, 32'd0);
        end
        res_valid = 1'b0;
        @(negedge clk);
        check("R8", {31'd0, flush}, 32'd0);
        fetch_op("R8", 32'h600, 1'b0, 1'b0, 32'h604, 1'b0, 1'b0);
        fetch_op("R5", a_pc(4), 1'b0, 1'b0, a_pc(4) + 32'd4, 1'b0, 1'b0);

        // R9/R11: push, pop, pop-empty fallback
        fetch_op("R9", 32'h1000, 1'b1, 1'b0, 32'h1004, 1'b0, 1'b0);
        fetch_op("R9", a_pc(2), 1'b0, 1'b1, 32'h1004, 1'b1, 1'b1);
        fetch_op("R11", 32'h2000, 1'b0, 1'b1, 32'h2004, 1'b0, 1'b0);
        fetch_op("R11", a_pc(2), 1'b0, 1'b1, a_tgt(2), 1'b1, 1'b0);

        // R10: five pushes, four pops newest first, then empty
        for (int k = 0; k < 5; k++) begin
            fetch_op("R10", 32'h3000 + 32'(k) * 32'h10, 1'b1, 1'b0,
                     32'h3004 + 32'(k) * 32'h10, 1'b0, 1'b0);
        end
        for (int k = 4; k >= 1; k--) begin
            fetch_op("R10", 32'h7000, 1'b0, 1'b1, 32'h3004 + 32'(k) * 32'h10, 1'b0, 1'b1);
        end
        fetch_op("R10", 32'h7000, 1'b0, 1'b1, 32'h7004, 1'b0, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule